// File: doc/BRIEF.md
# PIO Cycle Timing Converter

This block turns the nanosecond timing of a disk-interface PIO transfer mode into the clock counts used by a programmable cycle generator. It serves two attached drives. For each drive a small built-in table supplies three times for the selected mode: the address setup time, the active pulse time and the total cycle time. The block derives the recovery time from them and converts all three times into bus clocks. The conversion always rounds up. Each count is then clamped to the range the cycle generator can produce, and each drive gets one packed timing byte. The two drives share an address-setup setting, which is the larger of their two setup counts.

Software or a configuration sequencer sets the bus frequency in MHz, a presence flag and a mode code for each drive, and pulses `start`. All six conversions share one sequential restoring divider. When every count and both timing bytes are ready, the block pulses `done` for one cycle. A drive that is absent, or a bus frequency of zero, gives the safest defaults, and the divider is not run. The results stay on the outputs until the next start that the block accepts.

Top module: `pio_tc_conv`

## Requirements
- R1: Each clock count is floor((t_ns × bus_mhz + 999) / 1000), which is the ceiling of the time in bus clocks. For example, an 80 ns active time at 40 MHz gives 4 clocks.
- R2: The recovery time of a mode is its cycle time minus its setup time minus its active time. It is converted with the same rounding as R1.
- R3: A present drive's setup count is clamped to the range 1 to 4.
- R4: A present drive's data (active) count is clamped to the range 1 to 16.
- R5: A present drive's recovery count is clamped to the range 2 to 17.
- R6: An absent drive (its presence bit is 0) reports setup 1, data 1, recovery 2 and timing byte 0x00. Bit 0 of `drv_present` is drive A and bit 1 is drive B. After reset both drives are reported absent.
- R7: `setup_shared` is the larger of `setup_a` and `setup_b`.
- R8: The timing byte carries data−1 in bits 7:4 and recovery−2 in bits 3:0.
- R9: Once a start is accepted with a non-zero bus frequency, `busy` stays high. `done` is high for exactly one cycle, 6 × (NS_W + MHZ_W + 3) clock edges after the accepting edge (126 with the default parameters). `busy` is low while `done` is high.
- R10: A start accepted with `bus_mhz` = 0 makes both drives report the absent defaults. `done` then pulses in the cycle right after the accepting edge.
- R11: A `start` that arrives while `busy` is high is ignored: the results are those of the start already in progress, and no extra `done` is produced.
- R12: The mode table holds setup/active/cycle times in ns. Mode 0 is 70/165/600, mode 1 is 50/125/383, mode 2 is 30/100/240, mode 3 is 30/80/180 and mode 4 is 25/70/120. Mode codes 5 to 7 use the mode 0 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion (accepted only while idle) |
| bus_mhz | input | MHZ_W | Bus clock frequency in MHz; 0 means invalid |
| drv_present | input | 2 | Presence flags, bit 0 drive A, bit 1 drive B |
| mode_a | input | 3 | PIO mode code for drive A |
| mode_b | input | 3 | PIO mode code for drive B |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when all results are valid |
| setup_a | output | 3 | Drive A clamped setup count |
| setup_b | output | 3 | Drive B clamped setup count |
| data_a | output | 5 | Drive A clamped data count |
| data_b | output | 5 | Drive B clamped data count |
| rec_a | output | 5 | Drive A clamped recovery count |
| rec_b | output | 5 | Drive B clamped recovery count |
| tbyte_a | output | 8 | Drive A packed timing byte |
| tbyte_b | output | 8 | Drive B packed timing byte |
| setup_shared | output | 3 | Larger of the two setup counts |

## Verification
All results of an accepted start become valid together. With a non-zero frequency they are due 126 edges after the accepting edge, and with a zero frequency at the first edge after it. In both cases they are flagged by the one-cycle `done`. The driver records the cycle in which each start is accepted and queues the expected counts, bytes and due cycle, all computed from the mode table and the rounding rule. The monitor samples on the falling edge. At each `done` it compares every output and the cycle number with the oldest queued item. A `done` that arrives with an empty queue counts as a mismatch, which is how the check on an ignored start during `busy` works.

// File: rtl/pio_tc_pkg.sv
package pio_tc_pkg;

   localparam int TBL_W    = 10;
   localparam int NUM_MODES = 5;
   localparam int SLOTS    = 6;

   typedef struct packed {
      logic [TBL_W-1:0] setup_ns;
      logic [TBL_W-1:0] active_ns;
      logic [TBL_W-1:0] cycle_ns;
   } mode_times_t;

   // Codes beyond the table fall back to the slowest mode.
   function automatic mode_times_t mode_lookup(input logic [2:0] code);
      mode_times_t r;
      case (code)
         3'd1:    r = '{setup_ns: 10'd50, active_ns: 10'd125, cycle_ns: 10'd383};
         3'd2:    r = '{setup_ns: 10'd30, active_ns: 10'd100, cycle_ns: 10'd240};
         3'd3:    r = '{setup_ns: 10'd30, active_ns: 10'd80,  cycle_ns: 10'd180};
         3'd4:    r = '{setup_ns: 10'd25, active_ns: 10'd70,  cycle_ns: 10'd120};
         default: r = '{setup_ns: 10'd70, active_ns: 10'd165, cycle_ns: 10'd600};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pio_tc_div.sv
module pio_tc_div #(
   parameter int NUM_W   = 19,
   parameter int DIVISOR = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] dividend,
   output logic             valid,
   output logic [NUM_W-1:0] quotient
);
   localparam int DEN_W = $clog2(DIVISOR + 1);
   localparam int CNT_W = $clog2(NUM_W + 1);
   localparam logic [DEN_W:0] DIV_V = (DEN_W+1)'(DIVISOR);

   logic [DEN_W-1:0] rem_q;
   logic [CNT_W-1:0] cnt_q;
   logic [DEN_W:0]   trial;
   logic             fits;

   always_comb begin
      trial = {rem_q, quotient[NUM_W-1]};
      fits  = (trial >= DIV_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q    <= '0;
         cnt_q    <= '0;
         quotient <= '0;
         valid    <= 1'b0;
      end else if (go) begin
         rem_q    <= '0;
         cnt_q    <= CNT_W'(NUM_W);
         quotient <= dividend;
         valid    <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q    <= fits ? DEN_W'(trial - DIV_V) : trial[DEN_W-1:0];
         quotient <= {quotient[NUM_W-2:0], fits};
         cnt_q    <= cnt_q - 1'b1;
         valid    <= (cnt_q == CNT_W'(1));
      end else begin
         valid    <= 1'b0;
      end
   end
endmodule

// File: rtl/pio_tc_clamp.sv
module pio_tc_clamp #(
   parameter int Q_W = 19
) (
   input  logic           present,
   input  logic [Q_W-1:0] raw_setup,
   input  logic [Q_W-1:0] raw_data,
   input  logic [Q_W-1:0] raw_rec,
   output logic [2:0]     setup_cnt,
   output logic [4:0]     data_cnt,
   output logic [4:0]     rec_cnt,
   output logic [7:0]     tbyte
);
   always_comb begin
      if (!present) begin
         setup_cnt = 3'd1;
         data_cnt  = 5'd1;
         rec_cnt   = 5'd2;
      end else begin
         setup_cnt = (raw_setup < Q_W'(1)) ? 3'd1 :
                     (raw_setup > Q_W'(4)) ? 3'd4 : raw_setup[2:0];
         data_cnt  = (raw_data < Q_W'(1))  ? 5'd1 :
                     (raw_data > Q_W'(16)) ? 5'd16 : raw_data[4:0];
         rec_cnt   = (raw_rec < Q_W'(2))   ? 5'd2 :
                     (raw_rec > Q_W'(17))  ? 5'd17 : raw_rec[4:0];
      end
      tbyte = {4'(data_cnt - 5'd1), 4'(rec_cnt - 5'd2)};
   end
endmodule

// File: rtl/pio_tc_conv.sv
module pio_tc_conv #(
   parameter int NS_W     = 10,
   parameter int MHZ_W    = 8,
   parameter int NS_PER_US = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [MHZ_W-1:0] bus_mhz,
   input  logic [1:0]       drv_present,
   input  logic [2:0]       mode_a,
   input  logic [2:0]       mode_b,
   output logic             busy,
   output logic             done,
   output logic [2:0]       setup_a,
   output logic [2:0]       setup_b,
   output logic [4:0]       data_a,
   output logic [4:0]       data_b,
   output logic [4:0]       rec_a,
   output logic [4:0]       rec_b,
   output logic [7:0]       tbyte_a,
   output logic [7:0]       tbyte_b,
   output logic [2:0]       setup_shared
);
   import pio_tc_pkg::*;

   localparam int NUM_W = NS_W + MHZ_W + 1;
   localparam int IDX_W = $clog2(SLOTS);

   if (NS_W < TBL_W) begin : g_bad_ns
      $error("NS_W must hold the widest table time");
   end
   if (MHZ_W < 1 || MHZ_W > 12) begin : g_bad_mhz
      $error("MHZ_W out of supported range");
   end
   if (NS_PER_US < 2) begin : g_bad_div
      $error("NS_PER_US too small");
   end

   typedef enum logic {S_IDLE, S_RUN} state_t;

   state_t           state_q;
   logic [IDX_W-1:0] idx_q;
   logic             go_q;
   logic             rate_ok_q;
   logic [1:0]       pres_q;
   logic [MHZ_W-1:0] mhz_q;
   logic [NS_W-1:0]  t_q   [SLOTS];
   logic [NUM_W-1:0] raw_q [SLOTS];

   logic [NUM_W-1:0] dividend;
   logic             div_valid;
   logic [NUM_W-1:0] div_quo;
   mode_times_t      tm_a, tm_b;

   always_comb begin
      tm_a     = mode_lookup(mode_a);
      tm_b     = mode_lookup(mode_b);
      dividend = NUM_W'(t_q[idx_q]) * NUM_W'(mhz_q) + NUM_W'(NS_PER_US - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         idx_q     <= '0;
         go_q      <= 1'b0;
         done      <= 1'b0;
         rate_ok_q <= 1'b0;
         pres_q    <= '0;
         mhz_q     <= '0;
         for (int i = 0; i < SLOTS; i++) begin
            t_q[i]   <= '0;
            raw_q[i] <= '0;
         end
      end else begin
         go_q <= 1'b0;
         done <= 1'b0;
         case (state_q)
            S_IDLE: if (start) begin
               pres_q <= drv_present;
               mhz_q  <= bus_mhz;
               t_q[0] <= NS_W'(tm_a.setup_ns);
               t_q[1] <= NS_W'(tm_a.active_ns);
               t_q[2] <= NS_W'(tm_a.cycle_ns - tm_a.setup_ns - tm_a.active_ns);
               t_q[3] <= NS_W'(tm_b.setup_ns);
               t_q[4] <= NS_W'(tm_b.active_ns);
               t_q[5] <= NS_W'(tm_b.cycle_ns - tm_b.setup_ns - tm_b.active_ns);
               idx_q  <= '0;
               if (bus_mhz == '0) begin
                  rate_ok_q <= 1'b0;
                  done      <= 1'b1;
               end else begin
                  rate_ok_q <= 1'b1;
                  go_q      <= 1'b1;
                  state_q   <= S_RUN;
               end
            end
            S_RUN: if (div_valid) begin
               raw_q[idx_q] <= div_quo;
               if (idx_q == IDX_W'(SLOTS - 1)) begin
                  done    <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  go_q  <= 1'b1;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy = (state_q == S_RUN);

   pio_tc_div #(.NUM_W(NUM_W), .DIVISOR(NS_PER_US)) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go_q),
      .dividend (dividend),
      .valid    (div_valid),
      .quotient (div_quo)
   );

   logic [2:0] su_c [2];
   logic [4:0] da_c [2];
   logic [4:0] re_c [2];
   logic [7:0] tb_c [2];

   for (genvar d = 0; d < 2; d++) begin : g_drv
      pio_tc_clamp #(.Q_W(NUM_W)) clamp_i (
         .present   (pres_q[d] & rate_ok_q),
         .raw_setup (raw_q[3*d]),
         .raw_data  (raw_q[3*d+1]),
         .raw_rec   (raw_q[3*d+2]),
         .setup_cnt (su_c[d]),
         .data_cnt  (da_c[d]),
         .rec_cnt   (re_c[d]),
         .tbyte     (tb_c[d])
      );
   end

   assign setup_a      = su_c[0];
   assign setup_b      = su_c[1];
   assign data_a       = da_c[0];
   assign data_b       = da_c[1];
   assign rec_a        = re_c[0];
   assign rec_b        = re_c[1];
   assign tbyte_a      = tb_c[0];
   assign tbyte_b      = tb_c[1];
   assign setup_shared = (su_c[0] > su_c[1]) ? su_c[0] : su_c[1];
endmodule

// File: rtl/pio_tc_conv_chk.sv
module pio_tc_conv_chk #(
   parameter int MHZ_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [MHZ_W-1:0] bus_mhz,
   input logic             busy,
   input logic             done,
   input logic [2:0]       setup_a,
   input logic [2:0]       setup_b,
   input logic [4:0]       data_a,
   input logic [4:0]       data_b,
   input logic [4:0]       rec_a,
   input logic [4:0]       rec_b,
   input logic [2:0]       setup_shared
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R3
   setup_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (setup_a >= 3'd1 && setup_a <= 3'd4 && setup_b >= 3'd1 && setup_b <= 3'd4));
   // R4
   data_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (data_a >= 5'd1 && data_a <= 5'd16 && data_b >= 5'd1 && data_b <= 5'd16));
   // R5
   rec_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rec_a >= 5'd2 && rec_a <= 5'd17 && rec_b >= 5'd2 && rec_b <= 5'd17));
   // R7
   shared_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (setup_shared >= setup_a && setup_shared >= setup_b &&
                (setup_shared == setup_a || setup_shared == setup_b)));
   // R10
   zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && bus_mhz == '0) |=>
         (done && data_a == 5'd1 && rec_b == 5'd2 && setup_shared == 3'd1));
endmodule

bind pio_tc_conv pio_tc_conv_chk #(.MHZ_W(MHZ_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .bus_mhz      (bus_mhz),
   .busy         (busy),
   .done         (done),
   .setup_a      (setup_a),
   .setup_b      (setup_b),
   .data_a       (data_a),
   .data_b       (data_b),
   .rec_a        (rec_a),
   .rec_b        (rec_b),
   .setup_shared (setup_shared)
);

// File: tb/pio_tc_conv_tb.sv
module pio_tc_conv_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LAT_OK = 6 * (10 + 8 + 1 + 2);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] bus_mhz = '0;
   logic [1:0] drv_present = '0;
   logic [2:0] mode_a = '0, mode_b = '0;
   logic       busy, done;
   logic [2:0] setup_a, setup_b, setup_shared;
   logic [4:0] data_a, data_b, rec_a, rec_b;
   logic [7:0] tbyte_a, tbyte_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_tc_conv dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .bus_mhz(bus_mhz),
      .drv_present(drv_present), .mode_a(mode_a), .mode_b(mode_b),
      .busy(busy), .done(done), .setup_a(setup_a), .setup_b(setup_b),
      .data_a(data_a), .data_b(data_b), .rec_a(rec_a), .rec_b(rec_b),
      .tbyte_a(tbyte_a), .tbyte_b(tbyte_b), .setup_shared(setup_shared)
   );

   typedef struct {
      int su[2]; int da[2]; int re[2]; int tb[2]; int sh; int due; string tag;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0, n_bad = 0, cyc = 0;
   bit   finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int cdiv(int t, int m);
      return (t * m + 999) / 1000; // R1
   endfunction

   function automatic int lim(int v, int lo, int hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   function automatic void tbl(int m, output int s, output int a, output int c);
      case (m)   // R12
         1: begin s = 50; a = 125; c = 383; end
         2: begin s = 30; a = 100; c = 240; end
         3: begin s = 30; a = 80;  c = 180; end
         4: begin s = 25; a = 70;  c = 120; end
         default: begin s = 70; a = 165; c = 600; end
      endcase
   endfunction

   task automatic drive(int mhz, int pres, int ma, int mb, string tag);
      exp_t e;
      int md[2];
      md[0] = ma; md[1] = mb;
      for (int d = 0; d < 2; d++) begin
         int s, a, c;
         tbl(md[d], s, a, c);
         if (pres[d] && mhz != 0) begin
            e.su[d] = lim(cdiv(s, mhz), 1, 4);          // R3
            e.da[d] = lim(cdiv(a, mhz), 1, 16);         // R4
            e.re[d] = lim(cdiv(c - s - a, mhz), 2, 17); // R2 R5
         end else begin
            e.su[d] = 1; e.da[d] = 1; e.re[d] = 2;      // R6
         end
         e.tb[d] = ((e.da[d] - 1) << 4) | (e.re[d] - 2); // R8
      end
      e.sh  = (e.su[0] > e.su[1]) ? e.su[0] : e.su[1];  // R7
      @(negedge clk);
      e.due = cyc + 1 + ((mhz == 0) ? 0 : LAT_OK);      // R9 R10
      e.tag = tag;
      q.push_back(e);
      bus_mhz = 8'(mhz); drv_present = 2'(pres); mode_a = 3'(ma); mode_b = 3'(mb);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (q.size() == 0) begin
            chk("R11 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk({"R9 done cycle ", e.tag}, cyc, e.due);
            chk({"R3 setup_a ", e.tag}, setup_a, e.su[0]);
            chk({"R3 setup_b ", e.tag}, setup_b, e.su[1]);
            chk({"R4 data_a ", e.tag}, data_a, e.da[0]);
            chk({"R4 data_b ", e.tag}, data_b, e.da[1]);
            chk({"R5 rec_a ", e.tag}, rec_a, e.re[0]);
            chk({"R5 rec_b ", e.tag}, rec_b, e.re[1]);
            chk({"R8 tbyte_a ", e.tag}, tbyte_a, e.tb[0]);
            chk({"R8 tbyte_b ", e.tag}, tbyte_b, e.tb[1]);
            chk({"R7 shared ", e.tag}, setup_shared, e.sh);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset done", done, 0);
      chk("R9 reset busy", busy, 0);
      chk("R6 reset tbyte_a", tbyte_a, 0);
      chk("R6 reset shared", setup_shared, 1);

      drive(40, 3, 0, 0, "R2 mode0 40MHz");                wait_done();
      drive(40, 3, 3, 3, "R1 80ns at 40MHz");              wait_done();
      chk("R1 data rounds up to 4", data_a, 4);
      drive(33, 3, 4, 1, "R12 mixed modes 33MHz");         wait_done();
      drive(100, 3, 0, 2, "R4 R5 upper clamps 100MHz");    wait_done();
      drive(1, 3, 0, 4, "R5 lower clamps 1MHz");           wait_done();
      drive(66, 1, 2, 0, "R6 drive b absent");             wait_done();
      drive(0, 3, 0, 0, "R10 zero frequency");             wait_done();
      drive(50, 3, 6, 7, "R12 codes 6 7 use mode 0");      wait_done();
      drive(255, 2, 1, 4, "R6 drive a absent 255MHz");     wait_done();

      // R11: a second start while busy must be ignored
      drive(25, 3, 1, 2, "R11 first start kept");
      repeat (5) @(negedge clk);
      chk("R11 busy during run", busy, 1);
      bus_mhz = 8'd200; drv_present = 2'b00; mode_a = 3'd4; mode_b = 3'd4;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (LAT_OK + 10) @(negedge clk);
      chk("R11 queue drained", q.size(), 0);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule